// File: doc/BRIEF.md
# Cascadable Presettable Binary Up-Counter

This block is a synchronous binary up-counter, four bits wide by default. It can be preset from a parallel data word and chained with other stages to form wider counters. An active-low clear returns the count to zero. A parameter fixes, at build time, whether that clear acts at once or waits for the next rising clock edge.

An active-low load strobe copies the data word into the count on the next rising edge. Counting needs two active-high enables together: a parallel enable and a trickle enable. The terminal-count output is high when the count is all ones and the trickle enable is high. It depends on the trickle enable without passing through a register, so a downstream stage can use it directly as its own trickle enable.

For a wider counter, the terminal count of each stage drives the trickle enable of the next stage. Every stage shares the clock, the load strobe and the parallel enable. The count output comes straight from the count flip-flops. The terminal count is the only combinational output.

Top module: `presettable_counter`

## Requirements
- R1: The count advances through 0 to 2^WIDTH-1 in ascending order and goes from all ones (15 at WIDTH=4) back to 0.
- R2: When the clear is inactive, the count output changes only on a rising clock edge; changing inputs between edges leaves it unchanged.
- R3: With ASYNC_RESET=1, a low clr_n drives the count to 0 at once, without a clock edge, and holds it there whatever the other inputs are.
- R4: With ASYNC_RESET=0, a low clr_n makes the count 0 on the next rising edge, ahead of load and count; before that edge the count is unchanged.
- R5: When clr_n is high and load_n is low, the next rising edge copies din into the count, whatever the enables are.
- R6: When clr_n and load_n are high and en_par and en_trk are both high, the next rising edge adds one to the count.
- R7: When clr_n and load_n are high and either en_par or en_trk is low, the count holds its value across the edge.
- R8: tc equals en_trk AND (count is all ones), and it follows a change of en_trk without a clock edge.
- R9: Two stages, with the lower tc driving the upper en_trk and all other controls shared, count as one 8-bit counter, both when counting and when loaded while the lower tc is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; acts at once or on the edge, set by ASYNC_RESET |
| load_n | input | 1 | Active-low parallel load strobe |
| din | input | WIDTH | Parallel preset data |
| en_par | input | 1 | Parallel count enable, active high |
| en_trk | input | 1 | Trickle count enable, active high; also gates tc |
| q | output | WIDTH | Registered count value |
| tc | output | 1 | Terminal count: en_trk AND count all ones |

## Verification
The bench builds two 4-bit stages chained into an 8-bit counter with ASYNC_RESET=1, and a second chained pair with ASYNC_RESET=0. Both pairs get identical stimulus. Comparing the pairs exposes the only difference between the two clear styles: a clear asserted between edges empties one pair at once, while the other keeps its value until the edge. The chaining brings into reach the carry at 0x0F to 0x10, the full 8-bit wrap from 0xFF to 0x00, and a load that lands while the lower terminal count is high.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STEP  = 2'd2,
        OP_KEEP  = 2'd3
    } op_e;

    // Fixed precedence: clear, then load, then step, then keep.
    function automatic op_e pick_op(input logic clr_req,
                                    input logic ld_n,
                                    input logic step_ok);
        if (clr_req)
            return OP_CLEAR;
        else if (!ld_n)
            return OP_LOAD;
        else if (step_ok)
            return OP_STEP;
        else
            return OP_KEEP;
    endfunction

endpackage

// File: rtl/pcnt_mode_dec.sv
module pcnt_mode_dec
    import pcnt_pkg::*;
(
    input  logic clr_n,
    input  logic load_n,
    input  logic en_par,
    input  logic en_trk,
    output op_e  op
);
    logic step_ok;

    // The enable term includes the load strobe, so a load always masks counting.
    assign step_ok = en_par & en_trk & load_n;

    // While the clear is low, decoding a clear is harmless in asynchronous mode,
    // because the flops are already held at zero.
    always_comb op = pick_op(!clr_n, load_n, step_ok);

endmodule

// File: rtl/pcnt_next.sv
module pcnt_next
    import pcnt_pkg::*;
#(
    parameter int WIDTH = 4
)(
    input  op_e              op,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = din;
            OP_STEP:  nxt = cur + ONE;   // natural wrap from all ones to zero
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/pcnt_tc.sv
module pcnt_tc #(
    parameter int WIDTH = 4
)(
    input  logic [WIDTH-1:0] cur,
    input  logic             en_trk,
    output logic             tc
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    assign tc = en_trk & (cur == TOP);

endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
    import pcnt_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter bit ASYNC_RESET = 1'b1
)(
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             en_par,
    input  logic             en_trk,
    output logic [WIDTH-1:0] q,
    output logic             tc
);
    op_e              op;
    logic [WIDTH-1:0] cnt_r;
    logic [WIDTH-1:0] cnt_nxt;

    pcnt_mode_dec u_dec (
        .clr_n  (clr_n),
        .load_n (load_n),
        .en_par (en_par),
        .en_trk (en_trk),
        .op     (op)
    );

    pcnt_next #(.WIDTH(WIDTH)) u_next (
        .op  (op),
        .cur (cnt_r),
        .din (din),
        .nxt (cnt_nxt)
    );

    pcnt_tc #(.WIDTH(WIDTH)) u_tc (
        .cur    (cnt_r),
        .en_trk (en_trk),
        .tc     (tc)
    );

    generate
        if (ASYNC_RESET) begin : g_async_clr
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n)
                    cnt_r <= '0;
                else
                    cnt_r <= cnt_nxt;
            end
        end else begin : g_sync_clr
            always_ff @(posedge clk) begin
                cnt_r <= cnt_nxt;
            end
        end
    endgenerate

    assign q = cnt_r;

endmodule

// File: rtl/pcnt_checker.sv
module pcnt_checker #(
    parameter int WIDTH       = 4,
    parameter bit ASYNC_RESET = 1'b1
)(
    input logic             clk,
    input logic             clr_n,
    input logic             load_n,
    input logic [WIDTH-1:0] din,
    input logic             en_par,
    input logic             en_trk,
    input logic [WIDTH-1:0] q,
    input logic             tc
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    p_load_r5: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> (q == $past(din)));

    p_step_r6: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_par && en_trk) |=> (q == $past(q) + ONE));

    p_wrap_r1: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_par && en_trk && (&q)) |=> (q == '0));

    p_hold_r7: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(en_par && en_trk)) |=> $stable(q));

    p_tc_set_r8: assert property (@(posedge clk) disable iff (!clr_n)
        tc |-> (en_trk && (&q)));

    p_tc_req_r8: assert property (@(posedge clk) disable iff (!clr_n)
        (en_trk && (&q)) |-> tc);

    generate
        if (ASYNC_RESET) begin : g_chk_async
            p_async_clr_r3: assert property (@(posedge clk)
                !clr_n |-> (q == '0));
        end else begin : g_chk_sync
            p_sync_clr_r4: assert property (@(posedge clk)
                !clr_n |=> (q == '0));
        end
    endgenerate

endmodule

bind presettable_counter pcnt_checker #(
    .WIDTH       (WIDTH),
    .ASYNC_RESET (ASYNC_RESET)
) u_pcnt_checker (
    .clk    (clk),
    .clr_n  (clr_n),
    .load_n (load_n),
    .din    (din),
    .en_par (en_par),
    .en_trk (en_trk),
    .q      (q),
    .tc     (tc)
);

// File: tb/tb_presettable_counter.sv
module tb_presettable_counter;
    localparam int CLK_PERIOD = 10;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         clr_n = 1'b1;
    logic         load_n = 1'b1;
    logic [W-1:0] din_lo = '0;
    logic [W-1:0] din_hi = '0;
    logic         en_par = 1'b0;
    logic         en_trk = 1'b0;

    logic [W-1:0] q_lo_a, q_hi_a, q_lo_s, q_hi_s;
    logic         tc_lo_a, tc_hi_a, tc_lo_s, tc_hi_s;

    int   n_vec = 0;
    int   n_bad = 0;
    logic [7:0] exp_a = '0;
    logic [7:0] exp_s = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Asynchronous-clear pair.
    presettable_counter #(.WIDTH(W), .ASYNC_RESET(1'b1)) dut (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din_lo),
        .en_par(en_par), .en_trk(en_trk), .q(q_lo_a), .tc(tc_lo_a));
    presettable_counter #(.WIDTH(W), .ASYNC_RESET(1'b1)) dut_hi (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din_hi),
        .en_par(en_par), .en_trk(tc_lo_a), .q(q_hi_a), .tc(tc_hi_a));

    // Synchronous-clear pair.
    presettable_counter #(.WIDTH(W), .ASYNC_RESET(1'b0)) dut_s (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din_lo),
        .en_par(en_par), .en_trk(en_trk), .q(q_lo_s), .tc(tc_lo_s));
    presettable_counter #(.WIDTH(W), .ASYNC_RESET(1'b0)) dut_s_hi (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din_hi),
        .en_par(en_par), .en_trk(tc_lo_s), .q(q_hi_s), .tc(tc_hi_s));

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] expv);
        n_vec++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [7:0] model(input logic [7:0] cur);
        if (!clr_n)                 return 8'h00;
        else if (!load_n)           return {din_hi, din_lo};
        else if (en_par && en_trk)  return cur + 8'h01;
        else                        return cur;
    endfunction

    task automatic check_all(input string tag);
        logic tl_a, tl_s;
        tl_a = en_trk && (exp_a[3:0] == 4'hF);
        tl_s = en_trk && (exp_s[3:0] == 4'hF);
        chk({tag, " async count"}, {8'h00, q_hi_a, q_lo_a}, {8'h00, exp_a});
        chk({tag, " sync count"},  {8'h00, q_hi_s, q_lo_s}, {8'h00, exp_s});
        chk({tag, " R8 async tc"}, {14'h0, tc_hi_a, tc_lo_a},
            {14'h0, tl_a && (exp_a[7:4] == 4'hF), tl_a});
        chk({tag, " R8 sync tc"},  {14'h0, tc_hi_s, tc_lo_s},
            {14'h0, tl_s && (exp_s[7:4] == 4'hF), tl_s});
    endtask

    // One rising edge: update the model with the inputs held at the edge, then check.
    task automatic step(input string tag);
        @(posedge clk);
        exp_a = model(exp_a);
        exp_s = model(exp_s);
        #1;
        check_all(tag);
    endtask

    task automatic load8(input logic [7:0] v, input logic ep, input logic et);
        din_hi = v[7:4]; din_lo = v[3:0];
        load_n = 1'b0; en_par = ep; en_trk = et;
        step("R5 load");
        load_n = 1'b1;
    endtask

    task automatic t_reset;
        #2 clr_n = 1'b0;
        load_n = 1'b0; en_par = 1'b1; en_trk = 1'b1; din_lo = 4'h9; din_hi = 4'h6;
        step("R3 R4 reset");
        step("R3 R4 reset held");
        clr_n = 1'b1; load_n = 1'b1; en_par = 1'b0; en_trk = 1'b0;
    endtask

    task automatic t_count_run;
        load8(8'hF8, 1'b1, 1'b1);
        en_par = 1'b1; en_trk = 1'b1;
        for (int i = 0; i < 300; i++) step("R1 R6 R9 count");
    endtask

    task automatic t_hold;
        load8(8'h3E, 1'b0, 1'b0);
        en_par = 1'b0; en_trk = 1'b1;
        step("R7 hold par low");
        step("R7 hold par low");
        en_par = 1'b1; en_trk = 1'b0;
        step("R7 hold trk low");
        en_par = 1'b0; en_trk = 1'b0;
        step("R7 hold both low");
    endtask

    task automatic t_load_at_tc;
        load8(8'h2F, 1'b1, 1'b1);
        en_par = 1'b1; en_trk = 1'b1;
        #1 chk("R8 R9 tc high before load", {15'h0, tc_lo_a}, 16'h1);
        load8(8'h81, 1'b1, 1'b1);
        chk("R5 R9 load over carry", {8'h00, q_hi_a, q_lo_a}, 16'h0081);
        step("R6 R9 count after load");
    endtask

    task automatic t_tc_comb;
        load8(8'h0F, 1'b0, 1'b1);
        en_par = 1'b0; en_trk = 1'b1;
        step("R8 tc setup");
        @(negedge clk);
        en_trk = 1'b0;
        #1;
        chk("R8 tc falls without edge", {14'h0, tc_lo_a, tc_lo_s}, 16'h0);
        en_trk = 1'b1;
        #1;
        chk("R8 tc rises without edge", {14'h0, tc_lo_a, tc_lo_s}, 16'h3);
        load8(8'hFF, 1'b0, 1'b1);
        en_par = 1'b0; en_trk = 1'b1;
        step("R8 R9 upper tc");
        chk("R8 R9 upper tc high", {15'h0, tc_hi_a}, 16'h1);
    endtask

    task automatic t_no_edge_change;
        load8(8'h5A, 1'b0, 1'b0);
        @(negedge clk);
        din_lo = 4'h1; din_hi = 4'h2; load_n = 1'b0; en_par = 1'b1; en_trk = 1'b0;
        #1;
        chk("R2 no change between edges async", {8'h00, q_hi_a, q_lo_a}, 16'h005A);
        chk("R2 no change between edges sync",  {8'h00, q_hi_s, q_lo_s}, 16'h005A);
        load_n = 1'b1; en_par = 1'b0;
        step("R2 R7 after glitchy inputs");
    endtask

    task automatic t_async_vs_sync;
        load8(8'h55, 1'b0, 1'b0);
        @(negedge clk);
        load_n = 1'b0; en_par = 1'b1; en_trk = 1'b1; din_lo = 4'hC; din_hi = 4'h3;
        clr_n = 1'b0;
        #1;
        chk("R3 async clear immediate", {8'h00, q_hi_a, q_lo_a}, 16'h0000);
        chk("R4 sync clear waits for edge", {8'h00, q_hi_s, q_lo_s}, 16'h0055);
        exp_a = 8'h00;
        step("R3 R4 clear over load and count");
        clr_n = 1'b1; load_n = 1'b1;
        step("R6 count after clear");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_count_run();
        t_hold();
        t_load_at_tc();
        t_tc_comb();
        t_no_edge_change();
        t_async_vs_sync();
        #(CLK_PERIOD);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule